// File: doc/BRIEF.md
# Channel Status Block Transmit Sequencer

This block feeds the channel status stream of a serial digital audio transmitter. A 192-bit status block sits in six 32-bit words, A to F, on the `cs_words` input. At every frame boundary the sequencer hands one status bit to the frame formatter. It walks the words in order from A to F and takes each word least significant bit first. It also marks the first frame of every block so the formatter can choose the block-start preamble. Line coding and preamble generation belong to the formatter and are not part of this block.

Two flags report activity. `tx_busy` follows the transmit enable. It rises at once and is held until the next frame boundary after the enable goes away. `cs_busy` covers the part of a block in which status words are still being loaded. It rises when word A is loaded and drops when word F is loaded. Dropping the transmit enable also clears it at the next frame boundary. A separate status enable gates the status stream while the transmitter keeps running.

Top module: `cs_block_sequencer`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, the edge clears `cs_bit`, `block_start`, `tx_busy` and `cs_busy` to 0. The next block after reset starts from word A.
- R2: `tx_busy` is 1 after every clock edge at which `tx_en` is sampled high, whether or not `frame_start` is present.
- R3: `tx_busy` goes to 0 only at an edge where `frame_start` is 1 and `tx_en` is 0. If `tx_en` is low between frame boundaries, `tx_busy` holds its value.
- R4: A `frame_start` edge starts a block when `tx_en` and `cs_en` are both 1 and no block is in progress. From that edge, `cs_bit` equals bit 0 of word A, `block_start` is 1 and `cs_busy` is 1. Word k occupies bits `[32k+31:32k]` of `cs_words`, with A at k=0 and F at k=5.
- R5: Each later `frame_start` edge with both enables high moves to the next bit, least significant bit first. After bit 31 of a word comes bit 0 of the next word, in the order A to F. `cs_bit` and `block_start` change only at `frame_start` edges, and `block_start` is 0 on every frame except the first of a block.
- R6: A word's value is captured at the `frame_start` edge that presents its bit 0. A change to a word before that edge is transmitted. A change after that edge has no effect until the word is next loaded.
- R7: `cs_busy` drops to 0 at the edge that loads word F and stays 0 for the 32 frames of word F.
- R8: The `frame_start` edge after bit 31 of word F starts a new block from word A. At that edge `block_start` and `cs_busy` both return to 1.
- R9: A `frame_start` edge with `tx_en` low clears `cs_bit`, `block_start` and `cs_busy`. The next start after the enables return begins at word A.
- R10: A `frame_start` edge with `tx_en` high and `cs_en` low sets `cs_bit`, `block_start` and `cs_busy` to 0 and leaves `tx_busy` at 1. Raising `cs_en` again restarts at word A.
- R11: `cs_busy` is never 1 while `tx_busy` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_en | input | 1 | Transmit enable |
| cs_en | input | 1 | Channel status transmit enable |
| frame_start | input | 1 | One-cycle strobe at each audio frame boundary |
| cs_words | input | NUM_WORDS*WORD_W (192) | Status words, word A in the lowest 32 bits |
| cs_bit | output | 1 | Status bit for the current frame |
| block_start | output | 1 | High for the first frame of each block |
| tx_busy | output | 1 | Transmitter busy flag |
| cs_busy | output | 1 | Status word loading busy flag |

## Verification
The bench runs whole blocks and several partial ones against a reference model in the bench. It targets the wrap from word F back to word A. A design that miscounts the wrap either adds a 193rd frame or skips `block_start` on the new block. The bench rewrites a word just before its load and again just after it. A sequencer that captures the whole block at its start, or reads a word live, sends the wrong bits. It also lowers `tx_en` between frame boundaries, lowers `cs_en` alone, and drives `frame_start` on back-to-back cycles. A flag that drops at the enable edge instead of the frame boundary is caught here. So is one that does not restart at word A, or one that misses strobes on consecutive cycles.

// File: rtl/cs_seq_pkg.sv
// Package: shared constants and the per-frame action code of the
// channel status sequencer.
package cs_seq_pkg;

    localparam int CS_WORD_W_DEF    = 32;
    localparam int CS_NUM_WORDS_DEF = 6;

    // Action decided at each clock for the status shifter and counters.
    typedef enum logic [2:0] {
        ACT_HOLD  = 3'd0,   // no frame boundary this cycle
        ACT_STOP  = 3'd1,   // frame boundary with an enable low: clear
        ACT_START = 3'd2,   // frame boundary that loads word A
        ACT_NEXT  = 3'd3,   // frame boundary that loads the next word
        ACT_SHIFT = 3'd4    // frame boundary that moves to the next bit
    } cs_act_e;

endpackage

// File: rtl/cs_word_select.sv
// Module: cs_word_select
// Picks one status word out of the flat word bus by index.
// Assumes word k sits at bits [k*WORD_W +: WORD_W]; an index past the
// last word yields zero.
module cs_word_select #(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 6,
    parameter int IDX_W     = 3
) (
    input  logic [NUM_WORDS*WORD_W-1:0] words_i,
    input  logic [IDX_W-1:0]            idx_i,
    output logic [WORD_W-1:0]           word_o
);

    logic [WORD_W-1:0] word_arr [NUM_WORDS];

    // Unpack the flat bus into one entry per word.
    for (genvar k = 0; k < NUM_WORDS; k++) begin : g_unpack
        assign word_arr[k] = words_i[k*WORD_W +: WORD_W];
    end

    // Index match selects the word; no match leaves zero.
    always_comb begin
        word_o = '0;
        for (int k = 0; k < NUM_WORDS; k++) begin
            if (idx_i == IDX_W'(k)) word_o = word_arr[k];
        end
    end

endmodule

// File: rtl/cs_seq_ctrl.sv
// Module: cs_seq_ctrl
// Tracks the position inside the status block (word and bit), decides
// the action taken at each frame boundary, and drives the block-start
// marker and the status busy flag.
// Assumes frame_start is a single-cycle strobe; all state changes happen
// only on cycles where it is high (or in reset).
module cs_seq_ctrl
    import cs_seq_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 6,
    parameter int IDX_W     = 3,
    parameter int BIT_W     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start_i,
    input  logic             tx_en_i,
    input  logic             cs_en_i,
    output cs_act_e          act_o,
    output logic [IDX_W-1:0] load_idx_o,
    output logic             block_start_o,
    output logic             cs_busy_o
);

    localparam logic [IDX_W-1:0] LAST_WORD = IDX_W'(NUM_WORDS - 1);
    localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(WORD_W - 1);

    logic             run_q;
    logic [IDX_W-1:0] widx_q;
    logic [BIT_W-1:0] bidx_q;
    logic [IDX_W-1:0] widx_nx;

    assign widx_nx = widx_q + IDX_W'(1);

    // Choose what this cycle's frame boundary does to the stream.
    always_comb begin
        act_o = ACT_HOLD;
        if (frame_start_i) begin
            if (!(tx_en_i && cs_en_i))
                act_o = ACT_STOP;
            else if (!run_q || (widx_q == LAST_WORD && bidx_q == LAST_BIT))
                act_o = ACT_START;
            else if (bidx_q == LAST_BIT)
                act_o = ACT_NEXT;
            else
                act_o = ACT_SHIFT;
        end
    end

    // Word index handed to the selector for a load.
    assign load_idx_o = (act_o == ACT_NEXT) ? widx_nx : '0;

    // Position counters, block marker and status busy flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q         <= 1'b0;
            widx_q        <= '0;
            bidx_q        <= '0;
            block_start_o <= 1'b0;
            cs_busy_o     <= 1'b0;
        end else begin
            case (act_o)
                ACT_STOP: begin
                    run_q         <= 1'b0;
                    widx_q        <= '0;
                    bidx_q        <= '0;
                    block_start_o <= 1'b0;
                    cs_busy_o     <= 1'b0;
                end
                ACT_START: begin
                    run_q         <= 1'b1;
                    widx_q        <= '0;
                    bidx_q        <= '0;
                    block_start_o <= 1'b1;
                    cs_busy_o     <= 1'b1;
                end
                ACT_NEXT: begin
                    widx_q        <= widx_nx;
                    bidx_q        <= '0;
                    block_start_o <= 1'b0;
                    cs_busy_o     <= (widx_nx != LAST_WORD);
                end
                ACT_SHIFT: begin
                    bidx_q        <= bidx_q + BIT_W'(1);
                    block_start_o <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // The block marker only appears while status loading is busy.
    assert_marker_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        block_start_o |-> cs_busy_o);

    // The busy flag only rises on the frame that loads word A.
    assert_busy_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_busy_o) |-> block_start_o);

    // The busy flag only falls at a frame boundary.
    assert_busy_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cs_busy_o) && $past(rst_n)) |-> $past(frame_start_i));

endmodule

// File: rtl/cs_shifter.sv
// Module: cs_shifter
// Holds the status word being sent and presents its low bit as the
// frame's status bit. Loads a new word, shifts right by one, or clears,
// as the controller's action says.
// Assumes the selected word is valid in the cycle of a load action.
module cs_shifter
    import cs_seq_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cs_act_e           act_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              bit_o
);

    logic [WORD_W-1:0] sh_q;

    // Load, shift or clear the status word on frame boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            case (act_i)
                ACT_START, ACT_NEXT: sh_q <= word_i;
                ACT_SHIFT:           sh_q <= sh_q >> 1;
                ACT_STOP:            sh_q <= '0;
                default: ;
            endcase
        end
    end

    assign bit_o = sh_q[0];

    // A load presents the low bit of the word that was selected.
    assert_load_lsb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i == ACT_START || act_i == ACT_NEXT) |=> (bit_o == $past(word_i[0])));

endmodule

// File: rtl/cs_tx_flag.sv
// Module: cs_tx_flag
// Transmitter busy flag: set by the transmit enable, cleared only at a
// frame boundary seen with the enable low.
// Assumes frame_start marks the end of the current frame.
module cs_tx_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en_i,
    input  logic frame_start_i,
    output logic tx_busy_o
);

    // Set on enable, release at the frame boundary after the enable drops.
    always_ff @(posedge clk) begin
        if (!rst_n)             tx_busy_o <= 1'b0;
        else if (tx_en_i)       tx_busy_o <= 1'b1;
        else if (frame_start_i) tx_busy_o <= 1'b0;
    end

    assert_tx_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en_i |=> tx_busy_o);

    assert_tx_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(tx_busy_o) && $past(rst_n)) |-> ($past(frame_start_i) && !$past(tx_en_i)));

endmodule

// File: rtl/cs_block_sequencer.sv
// Module: cs_block_sequencer
// Streams a NUM_WORDS x WORD_W channel status block, one bit per audio
// frame, low bit of each word first, words in ascending order. Drives the
// block-start marker and the transmitter / status busy flags.
// Assumes frame_start is a one-cycle strobe per frame and that cs_words is
// stable in the cycle a word is loaded.
module cs_block_sequencer
    import cs_seq_pkg::*;
#(
    parameter int WORD_W    = CS_WORD_W_DEF,
    parameter int NUM_WORDS = CS_NUM_WORDS_DEF
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        tx_en,
    input  logic                        cs_en,
    input  logic                        frame_start,
    input  logic [NUM_WORDS*WORD_W-1:0] cs_words,
    output logic                        cs_bit,
    output logic                        block_start,
    output logic                        tx_busy,
    output logic                        cs_busy
);

    localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
    localparam int BIT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;

    cs_act_e           act;
    logic [IDX_W-1:0]  load_idx;
    logic [WORD_W-1:0] sel_word;

    cs_seq_ctrl #(
        .WORD_W    (WORD_W),
        .NUM_WORDS (NUM_WORDS),
        .IDX_W     (IDX_W),
        .BIT_W     (BIT_W)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_start_i (frame_start),
        .tx_en_i       (tx_en),
        .cs_en_i       (cs_en),
        .act_o         (act),
        .load_idx_o    (load_idx),
        .block_start_o (block_start),
        .cs_busy_o     (cs_busy)
    );

    cs_word_select #(
        .WORD_W    (WORD_W),
        .NUM_WORDS (NUM_WORDS),
        .IDX_W     (IDX_W)
    ) u_sel (
        .words_i (cs_words),
        .idx_i   (load_idx),
        .word_o  (sel_word)
    );

    cs_shifter #(
        .WORD_W (WORD_W)
    ) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .act_i  (act),
        .word_i (sel_word),
        .bit_o  (cs_bit)
    );

    cs_tx_flag u_txf (
        .clk           (clk),
        .rst_n         (rst_n),
        .tx_en_i       (tx_en),
        .frame_start_i (frame_start),
        .tx_busy_o     (tx_busy)
    );

    // Status loading never reports busy without the transmitter busy.
    assert_cs_within_tx_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cs_busy |-> tx_busy);

    // The status bit only moves at frame boundaries.
    assert_bit_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && $past(rst_n)) |=> $stable(cs_bit));

endmodule

// File: tb/test_cs_block_sequencer.sv
// Bench: behavioural reference model of the status stream, compared
// against the design after every clock edge.
module test_cs_block_sequencer;

    localparam int WORD_W    = 32;
    localparam int NUM_WORDS = 6;
    localparam int BLK_BITS  = WORD_W * NUM_WORDS;
    localparam int F_FIRST   = WORD_W * (NUM_WORDS - 1);

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic                rst_n;
    logic                tx_en;
    logic                cs_en;
    logic                frame_start;
    logic [BLK_BITS-1:0] cs_words;
    logic                cs_bit;
    logic                block_start;
    logic                tx_busy;
    logic                cs_busy;

    cs_block_sequencer i_cs_block_sequencer (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_en       (tx_en),
        .cs_en       (cs_en),
        .frame_start (frame_start),
        .cs_words    (cs_words),
        .cs_bit      (cs_bit),
        .block_start (block_start),
        .tx_busy     (tx_busy),
        .cs_busy     (cs_busy)
    );

    int    vectors     = 0;
    int    miscompares = 0;
    string cur_req     = "R1";

    // Reference model state.
    bit              m_run, m_bit, m_blk, m_csb, m_txb;
    int              m_pos;
    logic [WORD_W-1:0] m_word;

    // Advance the model by one clock edge from the requirements.
    task automatic model_edge();
        if (!rst_n) begin
            m_run = 0; m_bit = 0; m_blk = 0; m_csb = 0; m_txb = 0; m_pos = 0;
        end else begin
            if (tx_en) m_txb = 1;
            else if (frame_start) m_txb = 0;
            if (frame_start) begin
                if (!(tx_en && cs_en)) begin
                    m_run = 0; m_bit = 0; m_blk = 0; m_csb = 0; m_pos = 0;
                end else begin
                    if (!m_run || m_pos == BLK_BITS - 1) begin
                        m_pos = 0;
                        m_run = 1;
                    end else begin
                        m_pos++;
                    end
                    if (m_pos % WORD_W == 0)
                        m_word = cs_words[(m_pos / WORD_W) * WORD_W +: WORD_W];
                    m_bit = m_word[m_pos % WORD_W];
                    m_blk = (m_pos == 0);
                    m_csb = (m_pos < F_FIRST);
                end
            end
        end
    endtask

    task automatic compare();
        vectors++;
        if (cs_bit !== m_bit || block_start !== m_blk ||
            tx_busy !== m_txb || cs_busy !== m_csb) begin
            miscompares++;
            $display("FAIL %s t=%0t: got bit=%0b blk=%0b txb=%0b csb=%0b expected bit=%0b blk=%0b txb=%0b csb=%0b",
                     cur_req, $time, cs_bit, block_start, tx_busy, cs_busy,
                     m_bit, m_blk, m_txb, m_csb);
        end
    endtask

    // One clock: drive, let the edge pass, update the model, compare.
    task automatic step(input logic fs);
        frame_start = fs;
        @(posedge clk);
        model_edge();
        #5;
        compare();
    endtask

    task automatic frames(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            step(1'b1);
            for (int g = 0; g < gap; g++) step(1'b0);
        end
    endtask

    task automatic set_word(input int k, input logic [WORD_W-1:0] v);
        cs_words[k*WORD_W +: WORD_W] = v;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: run did not end, got hang expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; tx_en = 1'b0; cs_en = 1'b0; frame_start = 1'b0;
        m_word = '0;
        cs_words = '0;
        set_word(0, 32'h8000_0005);
        set_word(1, 32'hDEAD_BEEF);
        set_word(2, 32'h1234_5678);
        set_word(3, 32'h0F0F_00FF);
        set_word(4, 32'hCAFE_0001);
        set_word(5, 32'hA5A5_5A5A);

        // R1: reset state
        cur_req = "R1";
        step(1'b0); step(1'b1); step(1'b0);
        rst_n = 1'b1;
        step(1'b0); step(1'b1);

        // R2: tx_busy rises with no frame boundary; R10: status gated off
        cur_req = "R2";
        tx_en = 1'b1;
        step(1'b0); step(1'b0);
        cur_req = "R10";
        frames(3, 3);

        // R4: first frame of the block; R5: bit walk through words A..E
        cs_en = 1'b1;
        cur_req = "R4";
        frames(1, 2);
        cur_req = "R5";
        frames(F_FIRST - 1, 2);
        // R7: word F frames with cs_busy low
        cur_req = "R7";
        frames(WORD_W, 2);
        // R8: wrap to word A of the next block
        cur_req = "R8";
        frames(10, 2);

        // R6: rewrite word C before its load, word B after its load
        cur_req = "R6";
        frames(40, 1);
        set_word(2, 32'h0000_FFF0);
        set_word(1, 32'h5555_0000);
        frames(40, 1);

        // R3: tx_en drops between boundaries; flag waits for the boundary
        cur_req = "R3";
        tx_en = 1'b0;
        step(1'b0); step(1'b0);
        // R9: boundary with tx_en low clears the stream
        cur_req = "R9";
        frames(1, 2);
        frames(3, 2);
        tx_en = 1'b1;
        step(1'b0);
        frames(40, 2);

        // R10: status enable alone dropped, then restored
        cur_req = "R10";
        cs_en = 1'b0;
        frames(3, 2);
        cs_en = 1'b1;
        frames(5, 2);

        // R3: short tx_en pulse between boundaries
        cur_req = "R3";
        tx_en = 1'b0;
        frames(1, 2);
        tx_en = 1'b1;
        step(1'b0);
        tx_en = 1'b0;
        step(1'b0); step(1'b0); step(1'b0);
        frames(1, 1);

        // R5: back-to-back frame strobes across a block wrap (R8, R11)
        cur_req = "R5";
        tx_en = 1'b1;
        cs_en = 1'b1;
        frames(BLK_BITS + 20, 0);

        // R1: reset in the middle of a block, then restart from word A
        cur_req = "R1";
        rst_n = 1'b0;
        step(1'b0);
        rst_n = 1'b1;
        step(1'b0);
        frames(5, 1);

        finish_run();
    end

endmodule